// File: doc/BRIEF.md
# Scalar Bit-Manipulation Unit

This unit evaluates one single-operand bit-level function per accepted request. The operand is 32 or 64 bits wide. The available functions are:

- population count of ones or of zeros;
- lowest set bit and lowest clear bit;
- leading-one search;
- search for the first bit that differs from the sign;
- bit reversal;
- sign extension from a byte or a halfword;
- nibble-group compression (quad mask) and nibble-group expansion (whole-quad mask);
- setting or clearing one bit of a destination word.

The opcode arrives with a generation select, because two opcode numberings are in use. A decoder maps both numberings to one internal operation kind.

Each request is presented for one cycle on `in_valid` and its result appears one cycle later. The result comes with `flag`, a condition bit, and `flag_we`, which says whether the condition register must take that bit. The surrounding pipeline supplies operands and retires results. Register-file access and sequencing stay outside the unit.

The control is a two-state machine. `ST_IDLE` means no result is presented. `ST_ISSUE` means a result is on the outputs. The transition "accept" (`in_valid` high) enters `ST_ISSUE` from either state. The transition "drain" (`in_valid` low) returns to `ST_IDLE`.

Top module: `sbit_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `flag_we` is never high without `out_valid`. Reset clears `out_valid`, `flag_we`, `flag` and `result`.
- R2: Population count. Old opcodes 15 and 16 count ones, 32-bit and 64-bit forms. Old opcodes 13 and 14 count zeros, 32-bit and 64-bit forms. The count is written to `result`, `flag` is 1 when the count is non-zero, and `flag_we` is 1.
- R3: Lowest clear bit (old opcodes 17/18) and lowest set bit (old opcodes 19/20) return the index of the lowest matching bit within the operand width. When no bit matches they return 0xFFFFFFFF. `flag_we` is 0.
- R4: Leading-one search (old opcodes 21/22) returns how many bits lie above the highest set bit, counted from the operand's MSB. It returns 0xFFFFFFFF for a zero operand. `flag_we` is 0.
- R5: Signed search (old opcodes 23/24) scans down from the MSB for the first bit that differs from the sign bit and returns `width-1-index`. It returns 0xFFFFFFFF when every bit equals the sign. `flag_we` is 0.
- R6: Quad mask (old opcodes 44/45) sets result bit i when nibble i of the source is non-zero. It covers 8 nibbles in the 32-bit form and 16 in the 64-bit form. `flag` is 1 when the result is non-zero, and `flag_we` is 1.
- R7: Whole-quad mask (old opcodes 9/10) sets all four bits of a nibble when any bit of that source nibble is set, and clears the nibble otherwise. `flag` is 1 when the result is non-zero, and `flag_we` is 1.
- R8: Bit clear (old opcodes 27/28) and bit set (old opcodes 29/30) change only bit (`src` mod 32) or bit (`src` mod 64) of `dst` and return the modified word. `flag_we` is 0.
- R9: Bit reverse (old opcodes 11/12) mirrors the operand within its width. Sign extension copies bit 7 (old opcode 25) or bit 15 (old opcode 26) upward to bit 31. Both leave `flag_we` at 0.
- R10: With `gen_sel`=0 the opcodes above apply. With `gen_sel`=1, codes 6..27 select old code +3 and codes 40..41 select old code +4.
- R11: An opcode outside these sets still produces `out_valid`, with `result` 0 and `flag_we` 0.
- R12: Every 32-bit form, and both sign extensions, write zeros to `result[63:32]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| gen_sel | input | 1 | 0: older opcode numbering, 1: newer |
| opcode | input | 7 | Operation code |
| src | input | 64 | Source operand |
| dst | input | 64 | Destination word for bit set/clear |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Computed value |
| flag | output | 1 | Condition bit |
| flag_we | output | 1 | Condition register update enable |

## Verification
The assertions check these rules on every cycle:

- the one-cycle latency;
- the gating of `flag_we` by `out_valid`;
- agreement between `flag` and a non-zero result whenever the flag is written;
- the silent flag and clear upper half of sign extension;
- the range of lowest-bit results;
- the zero result for an unused code.

Some behaviour only the bench scenarios can show, because it needs the actual values: the -1 sentinels, the sign-relative search, modulo bit indexing, nibble compression and expansion, and the mapping of the newer numbering. The bench covers these with directed cases and a sweep of every code in both numberings.

// File: rtl/sbit_pkg.sv
package sbit_pkg;

    typedef enum logic [3:0] {
        K_NONE, K_CNT0, K_CNT1, K_FF0, K_FF1, K_FLBIT, K_FLSGN,
        K_BREV, K_SEXT8, K_SEXT16, K_BCLR, K_BSET, K_QMASK, K_WQM
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  wide;
    } dec_t;

    typedef enum logic {
        ST_IDLE,
        ST_ISSUE
    } st_e;

endpackage

// File: rtl/sbit_decode.sv
module sbit_decode
    import sbit_pkg::*;
#(
    parameter int OPC_W = 7
) (
    input  logic             gen_sel,
    input  logic [OPC_W-1:0] opcode,
    output dec_t             dec
);

    logic [OPC_W-1:0] canon;

    // Map the newer numbering onto the older one.
    always_comb begin
        canon = opcode;
        if (gen_sel) begin
            if (opcode >= OPC_W'(6) && opcode <= OPC_W'(27))
                canon = opcode + OPC_W'(3);
            else if (opcode == OPC_W'(40) || opcode == OPC_W'(41))
                canon = opcode + OPC_W'(4);
            else
                canon = '0;
        end
    end

    always_comb begin
        dec.kind = K_NONE;
        dec.wide = 1'b0;
        case (canon)
            OPC_W'(9):  begin dec.kind = K_WQM;    dec.wide = 1'b0; end
            OPC_W'(10): begin dec.kind = K_WQM;    dec.wide = 1'b1; end
            OPC_W'(11): begin dec.kind = K_BREV;   dec.wide = 1'b0; end
            OPC_W'(12): begin dec.kind = K_BREV;   dec.wide = 1'b1; end
            OPC_W'(13): begin dec.kind = K_CNT0;   dec.wide = 1'b0; end
            OPC_W'(14): begin dec.kind = K_CNT0;   dec.wide = 1'b1; end
            OPC_W'(15): begin dec.kind = K_CNT1;   dec.wide = 1'b0; end
            OPC_W'(16): begin dec.kind = K_CNT1;   dec.wide = 1'b1; end
            OPC_W'(17): begin dec.kind = K_FF0;    dec.wide = 1'b0; end
            OPC_W'(18): begin dec.kind = K_FF0;    dec.wide = 1'b1; end
            OPC_W'(19): begin dec.kind = K_FF1;    dec.wide = 1'b0; end
            OPC_W'(20): begin dec.kind = K_FF1;    dec.wide = 1'b1; end
            OPC_W'(21): begin dec.kind = K_FLBIT;  dec.wide = 1'b0; end
            OPC_W'(22): begin dec.kind = K_FLBIT;  dec.wide = 1'b1; end
            OPC_W'(23): begin dec.kind = K_FLSGN;  dec.wide = 1'b0; end
            OPC_W'(24): begin dec.kind = K_FLSGN;  dec.wide = 1'b1; end
            OPC_W'(25): begin dec.kind = K_SEXT8;  dec.wide = 1'b0; end
            OPC_W'(26): begin dec.kind = K_SEXT16; dec.wide = 1'b0; end
            OPC_W'(27): begin dec.kind = K_BCLR;   dec.wide = 1'b0; end
            OPC_W'(28): begin dec.kind = K_BCLR;   dec.wide = 1'b1; end
            OPC_W'(29): begin dec.kind = K_BSET;   dec.wide = 1'b0; end
            OPC_W'(30): begin dec.kind = K_BSET;   dec.wide = 1'b1; end
            OPC_W'(44): begin dec.kind = K_QMASK;  dec.wide = 1'b0; end
            OPC_W'(45): begin dec.kind = K_QMASK;  dec.wide = 1'b1; end
            default:    begin dec.kind = K_NONE;   dec.wide = 1'b0; end
        endcase
    end

endmodule

// File: rtl/sbit_scan.sv
module sbit_scan
    import sbit_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  dec_t              dec,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] res,
    output logic              flag
);

    localparam int HALF  = DATA_W / 2;
    localparam int IDX_W = $clog2(DATA_W) + 1;

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] vec;
    logic [DATA_W-1:0] sentinel;
    logic [IDX_W-1:0]  lim;
    logic [IDX_W-1:0]  cnt;
    logic [IDX_W-1:0]  lo_pos;
    logic [IDX_W-1:0]  hi_pos;
    logic              lo_hit;
    logic              sgn;

    assign mask     = dec.wide ? {DATA_W{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
    assign sentinel = {{HALF{1'b0}}, {HALF{1'b1}}};
    assign lim      = dec.wide ? IDX_W'(DATA_W) : IDX_W'(HALF);
    assign sgn      = dec.wide ? src[DATA_W-1] : src[HALF-1];

    // Select the bit pattern that the count or search operates on.
    always_comb begin
        unique case (dec.kind)
            K_CNT0, K_FF0: vec = ~src & mask;
            K_FLSGN:       vec = (src ^ {DATA_W{sgn}}) & mask;
            default:       vec = src & mask;
        endcase
    end

    // Count, lowest hit and highest hit.
    always_comb begin
        cnt    = '0;
        lo_hit = 1'b0;
        lo_pos = '0;
        hi_pos = '0;
        for (int i = 0; i < DATA_W; i++) begin
            cnt = cnt + IDX_W'(vec[i]);
            if (vec[i] && !lo_hit) begin
                lo_hit = 1'b1;
                lo_pos = IDX_W'(i);
            end
            if (vec[i])
                hi_pos = IDX_W'(i);
        end
    end

    always_comb begin
        res  = '0;
        flag = 1'b0;
        unique case (dec.kind)
            K_CNT0, K_CNT1: begin
                res  = {{(DATA_W-IDX_W){1'b0}}, cnt};
                flag = (cnt != '0);
            end
            K_FF0, K_FF1:
                res = lo_hit ? {{(DATA_W-IDX_W){1'b0}}, lo_pos} : sentinel;
            K_FLBIT, K_FLSGN:
                res = (|vec) ? {{(DATA_W-IDX_W){1'b0}}, (lim - IDX_W'(1) - hi_pos)}
                             : sentinel;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/sbit_shape.sv
module sbit_shape
    import sbit_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  dec_t              dec,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst,
    output logic [DATA_W-1:0] res,
    output logic              flag
);

    localparam int HALF  = DATA_W / 2;
    localparam int NIBS  = DATA_W / 4;
    localparam int SH_W  = $clog2(DATA_W);

    logic [DATA_W-1:0] mask;
    logic [NIBS-1:0]   nz;
    logic [DATA_W-1:0] wq;
    logic [DATA_W-1:0] rev_w;
    logic [DATA_W-1:0] rev_n;
    logic [SH_W-1:0]   bidx;
    logic [DATA_W-1:0] onehot;

    assign mask = dec.wide ? {DATA_W{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};

    // Per-nibble reduction and expansion.
    for (genvar g = 0; g < NIBS; g++) begin : g_nib
        assign nz[g]         = |src[4*g +: 4];
        assign wq[4*g +: 4]  = {4{nz[g]}};
    end

    // Bit mirrors in both widths.
    for (genvar b = 0; b < DATA_W; b++) begin : g_rev
        assign rev_w[b] = src[DATA_W-1-b];
    end
    for (genvar b = 0; b < HALF; b++) begin : g_revn
        assign rev_n[b] = src[HALF-1-b];
    end
    assign rev_n[DATA_W-1:HALF] = '0;

    assign bidx   = dec.wide ? src[SH_W-1:0] : {1'b0, src[SH_W-2:0]};
    assign onehot = {{(DATA_W-1){1'b0}}, 1'b1} << bidx;

    always_comb begin
        res  = '0;
        flag = 1'b0;
        unique case (dec.kind)
            K_BREV:   res = dec.wide ? rev_w : rev_n;
            K_SEXT8:  res = {{HALF{1'b0}}, {(HALF-8){src[7]}}, src[7:0]};
            K_SEXT16: res = {{HALF{1'b0}}, {(HALF-16){src[15]}}, src[15:0]};
            K_BCLR:   res = (dst & ~onehot) & mask;
            K_BSET:   res = (dst | onehot) & mask;
            K_QMASK: begin
                res  = {{(DATA_W-NIBS){1'b0}}, nz & mask[NIBS-1:0]} ;
                if (!dec.wide)
                    res[NIBS-1:NIBS/2] = '0;
                flag = |(src & mask);
            end
            K_WQM: begin
                res  = wq & mask;
                flag = |(src & mask);
            end
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/sbit_unit.sv
module sbit_unit
    import sbit_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int OPC_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              gen_sel,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              flag,
    output logic              flag_we
);

    dec_t              dec;
    logic [DATA_W-1:0] scan_res;
    logic [DATA_W-1:0] shape_res;
    logic              scan_flag;
    logic              shape_flag;
    logic [DATA_W-1:0] res_next;
    logic              we_next;
    st_e               state;
    st_e               state_next;
    logic [DATA_W-1:0] res_q;
    logic              flag_q;
    logic              we_q;

    sbit_decode #(.OPC_W(OPC_W)) u_decode (
        .gen_sel (gen_sel),
        .opcode  (opcode),
        .dec     (dec)
    );

    sbit_scan #(.DATA_W(DATA_W)) u_scan (
        .dec  (dec),
        .src  (src),
        .res  (scan_res),
        .flag (scan_flag)
    );

    sbit_shape #(.DATA_W(DATA_W)) u_shape (
        .dec  (dec),
        .src  (src),
        .dst  (dst),
        .res  (shape_res),
        .flag (shape_flag)
    );

    always_comb begin
        unique case (dec.kind)
            K_CNT0, K_CNT1, K_FF0, K_FF1, K_FLBIT, K_FLSGN: res_next = scan_res;
            K_NONE:  res_next = '0;
            default: res_next = shape_res;
        endcase
        we_next = (dec.kind == K_CNT0) || (dec.kind == K_CNT1) ||
                  (dec.kind == K_QMASK) || (dec.kind == K_WQM);
    end

    // Next-state: accept enters ST_ISSUE, drain returns to ST_IDLE.
    always_comb begin
        unique case (state)
            ST_IDLE:  state_next = in_valid ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_next = in_valid ? ST_ISSUE : ST_IDLE;
            default:  state_next = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            flag_q <= 1'b0;
            we_q   <= 1'b0;
        end else if (in_valid) begin
            res_q  <= res_next;
            flag_q <= scan_flag | shape_flag;
            we_q   <= we_next;
        end
    end

    assign out_valid = (state == ST_ISSUE);
    assign result    = res_q;
    assign flag      = flag_q;
    assign flag_we   = we_q && (state == ST_ISSUE);

endmodule

// File: rtl/sbit_unit_sva.sv
module sbit_unit_sva #(
    parameter int DATA_W = 64,
    parameter int OPC_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              gen_sel,
    input logic [OPC_W-1:0]  opcode,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              flag,
    input logic              flag_we
);

    localparam int HALF = DATA_W / 2;

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_drain_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_we_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> out_valid);

    assert_flag_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_we) |-> (flag == (result != '0)));

    assert_sext_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !gen_sel && opcode == OPC_W'(25)) |=>
        (!flag_we && result[DATA_W-1:HALF] == '0));

    assert_ff_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !gen_sel && opcode == OPC_W'(17)) |=>
        (result == DATA_W'({HALF{1'b1}}) || result < DATA_W'(HALF)));

    assert_unknown_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !gen_sel && opcode == OPC_W'(40)) |=>
        (result == '0 && !flag_we));

endmodule

bind sbit_unit sbit_unit_sva #(.DATA_W(DATA_W), .OPC_W(OPC_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .gen_sel   (gen_sel),
    .opcode    (opcode),
    .out_valid (out_valid),
    .result    (result),
    .flag      (flag),
    .flag_we   (flag_we)
);

// File: tb/sbit_unit_bench.sv
module sbit_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        gen_sel = 1'b0;
    logic [6:0]  opcode = '0;
    logic [63:0] src = '0;
    logic [63:0] dst = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        flag;
    logic        flag_we;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [63:0] res;
        logic        fl;
        logic        we;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sbit_unit u_sbit_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .gen_sel(gen_sel),
        .opcode(opcode), .src(src), .dst(dst), .out_valid(out_valid),
        .result(result), .flag(flag), .flag_we(flag_we)
    );

    function automatic logic [63:0] neg1();
        return 64'h0000_0000_FFFF_FFFF;
    endfunction

    // Reference model built from the requirement text.
    function automatic exp_t model(input logic g, input logic [6:0] op,
                                   input logic [63:0] s, input logic [63:0] d);
        exp_t e;
        int   c, w, k;
        logic [63:0] v;
        logic sg;
        e.res = '0; e.fl = 1'b0; e.we = 1'b0; e.tag = "R10";
        c = int'(op);
        if (g) begin
            if (c >= 6 && c <= 27) c = c + 3;
            else if (c == 40 || c == 41) c = c + 4;
            else c = 0;
        end
        w = (c inside {10, 12, 14, 16, 18, 20, 22, 24, 28, 30, 45}) ? 64 : 32;
        v = (w == 64) ? s : {32'h0, s[31:0]};
        case (c)
            13, 14, 15, 16: begin
                k = 0;
                for (int i = 0; i < w; i++) if (v[i] == (c >= 15)) k++;
                e.res = 64'(k); e.fl = (k != 0); e.we = 1'b1;
            end
            17, 18, 19, 20: begin
                e.res = neg1();
                for (int i = w - 1; i >= 0; i--) if (v[i] == (c >= 19)) e.res = 64'(i);
            end
            21, 22: begin
                e.res = neg1();
                for (int i = 0; i < w; i++) if (v[i]) e.res = 64'(w - 1 - i);
            end
            23, 24: begin
                e.res = neg1();
                sg = v[w-1];
                for (int i = 0; i < w; i++) if (v[i] != sg) e.res = 64'(w - 1 - i);
            end
            11, 12: for (int i = 0; i < w; i++) e.res[i] = v[w-1-i];
            25: e.res = {32'h0, {24{s[7]}}, s[7:0]};
            26: e.res = {32'h0, {16{s[15]}}, s[15:0]};
            27, 28, 29, 30: begin
                e.res = (w == 64) ? d : {32'h0, d[31:0]};
                k = (w == 64) ? int'(s[5:0]) : int'(s[4:0]);
                e.res[k] = (c >= 29);
            end
            44, 45: begin
                for (int i = 0; i < w / 4; i++) e.res[i] = (v[4*i +: 4] != 4'h0);
                e.fl = (e.res != 0); e.we = 1'b1;
            end
            9, 10: begin
                for (int i = 0; i < w / 4; i++)
                    e.res[4*i +: 4] = (v[4*i +: 4] != 4'h0) ? 4'hF : 4'h0;
                e.fl = (e.res != 0); e.we = 1'b1;
            end
            default: ;
        endcase
        return e;
    endfunction

    task automatic issue(input string tag, input logic g, input logic [6:0] op,
                         input logic [63:0] s, input logic [63:0] d);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; gen_sel = g; opcode = op; src = s; dst = d;
        e = model(g, op, s, d);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Check a directed case against a hand-computed value as well as the model.
    task automatic direct(input string tag, input logic g, input logic [6:0] op,
                          input logic [63:0] s, input logic [63:0] d,
                          input logic [63:0] hand);
        exp_t e;
        e = model(g, op, s, d);
        checks++;
        if (e.res !== hand) begin
            errors++;
            $display("FAIL %s model-vs-hand op=%0d act=%h exp=%h", tag, op, e.res, hand);
        end
        issue(tag, g, op, s, d);
    endtask

    // Scoreboard monitor.
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R1 unexpected out_valid act=1 exp=0");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    checks++;
                    if (result !== e.res || flag_we !== e.we || (e.we && flag !== e.fl)) begin
                        errors++;
                        $display("FAIL %s act res=%h we=%b fl=%b exp res=%h we=%b fl=%b",
                                 e.tag, result, flag_we, flag, e.res, e.we, e.fl);
                    end
                end
            end else if (flag_we) begin
                checks++; errors++;
                $display("FAIL R1 flag_we without out_valid act=1 exp=0");
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] lf;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || flag_we !== 1'b0 || result !== 64'h0 || flag !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset state act=%b%b%h exp=00 zero", out_valid, flag_we, result);
        end
        rst_n = 1'b1;
        idle_cycles(2);

        // R2 population counts
        direct("R2", 0, 15, 64'hF0F0_0000_0000_000F, 0, 64'd4);
        direct("R2", 0, 14, 64'hFFFF_FFFF_FFFF_FFFF, 0, 64'd0);
        direct("R2", 0, 13, 64'hFFFF_FFFF_0000_0000, 0, 64'd32);
        direct("R2", 0, 16, 64'h8000_0000_0000_0001, 0, 64'd2);
        // R3 lowest-bit searches
        direct("R3", 0, 17, 64'h0000_0000_FFFF_FFFF, 0, neg1());
        direct("R3", 0, 20, 64'h8000_0000_0000_0000, 0, 64'd63);
        direct("R3", 0, 17, 64'h0000_0000_0000_0007, 0, 64'd3);
        direct("R3", 0, 19, 64'hFFFF_FFFF_0000_0000, 0, neg1());
        // R4 leading-one search
        direct("R4", 0, 21, 64'h0000_0000_0001_0000, 0, 64'd15);
        direct("R4", 0, 22, 64'h0, 0, neg1());
        direct("R4", 0, 21, 64'hFFFF_0000_0000_0000, 0, neg1());
        // R5 signed search
        direct("R5", 0, 23, 64'h0000_0000_FFFF_8000, 0, 64'd17);
        direct("R5", 0, 24, 64'hFFFF_FFFF_FFFF_FFFF, 0, neg1());
        direct("R5", 0, 23, 64'h0000_0000_4000_0000, 0, 64'd1);
        direct("R5", 0, 24, 64'h0, 0, neg1());
        // R6 quad mask
        direct("R6", 0, 44, 64'h0000_0000_00F0_0100, 0, 64'h24);
        direct("R6", 0, 45, 64'h0, 0, 64'h0);
        direct("R6", 0, 45, 64'h1000_0000_0000_0001, 0, 64'h8001);
        // R7 whole-quad mask
        direct("R7", 0, 9, 64'h0000_0000_0010_8001, 0, 64'h0000_0000_00F0_F00F);
        direct("R7", 0, 10, 64'h2000_0000_0000_0000, 0, 64'hF000_0000_0000_0000);
        // R8 bit set and clear, index wraps
        direct("R8", 0, 29, 64'd37, 64'h0, 64'h20);
        direct("R8", 0, 28, 64'd70, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFBF);
        // R9 reverse and sign extension; R12 upper half zero
        direct("R9", 0, 11, 64'hFFFF_FFFF_0000_0001, 0, 64'h0000_0000_8000_0000);
        direct("R9", 0, 25, 64'h0000_0000_0000_0080, 0, 64'h0000_0000_FFFF_FF80);
        direct("R12", 0, 26, 64'hFFFF_FFFF_0000_7FFF, 0, 64'h0000_0000_0000_7FFF);
        direct("R9", 0, 12, 64'h0000_0000_0000_0003, 0, 64'hC000_0000_0000_0000);
        idle_cycles(2);
        // R10 newer numbering
        direct("R10", 1, 16, 64'h0000_0000_0000_0100, 0, 64'd8);
        direct("R10", 1, 41, 64'h0000_0000_0000_F000, 0, 64'h8);
        direct("R10", 1, 6, 64'h0000_0000_0000_0020, 0, 64'hF0);
        // R11 unused codes
        direct("R11", 0, 40, 64'hFFFF, 0, 64'h0);
        direct("R11", 1, 3, 64'hFFFF, 0, 64'h0);
        direct("R11", 0, 31, 64'hFFFF, 0, 64'h0);
        idle_cycles(1);

        // Sweep all codes in both numberings with pseudo-random operands.
        lf = 64'hACE1_2345_6789_BEEF;
        for (int g = 0; g < 2; g++) begin
            for (int op = 0; op < 48; op++) begin
                lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
                issue("R10", g[0], 7'(op), lf, ~lf);
            end
        end
        idle_cycles(4);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1 pending results act=%0d exp=0", sb.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule